// File: doc/BRIEF.md
# DDR4 Column Command Spacing Enforcer

This block sits between the column-command queue of a DRAM controller and the command bus. It takes one READ or WRITE at a time, with a bank group, a bank and a column address, over a valid/ready handshake. It holds the command back until every column-to-column spacing rule is met and then places it on the bus for exactly one clock. On every other clock the bus carries a deselect.

The gap a new command needs depends on what came before it. A command to a different bank group than the previous one needs the short delay. A command to the same bank group as the previous command to that group needs the long delay. A READ that follows a WRITE in the same bank group must also wait for the end of the write data burst plus the write-to-read turnaround.

Each limit is given twice, once as a clock count and once in picoseconds. The picosecond value is rounded up to whole clocks of the configured period, and the larger of the two values is enforced. Per-bank-group down-counters and one global down-counter track the limits. The counters are loaded when a command is issued, and a new command may go out only once every counter that applies to it has reached zero.

Top module: `col_cmd_spacer`

## Requirements
- R1: A command is accepted on a clock edge where `in_valid` and `in_ready` are both high. It appears on `cmd_o` in the following cycle for exactly one cycle, with the bank group, bank and column it was accepted with. While `in_valid` is high and `in_ready` is low, the requester holds the command stable.
- R2: Two issued commands that target different bank groups, and that are consecutive on the bus, are at least the short delay apart: 4 clocks with the defaults.
- R3: Two issued commands to the same bank group are at least the long delay apart: 6 clocks with the defaults.
- R4: A READ issued to a bank group after a WRITE to that bank group is at least (write data end + write-to-read turnaround) clocks after the WRITE: 8 + 6 = 14 clocks with the defaults.
- R5: No command waits longer than needed. A command is issued at the earliest cycle that is at least one cycle after it is presented and that satisfies R2, R3 and R4.
- R6: `cmd_o` is encoded as 0 = deselect, 1 = READ, 2 = WRITE. On deselect cycles, `cmd_bg_o`, `cmd_bank_o` and `cmd_col_o` are driven to zero.
- R7: Reset drives a deselect and clears all counters, so `in_ready` is high and the first command after reset is issued one cycle after it is presented.
- R8: Each enforced limit is the larger of its clock count and its picosecond value divided by the clock period, rounded up. With a 1250 ps clock the defaults are: short delay max(4, 2500 ps) = 4, long delay max(5, 7500 ps) = 6, turnaround max(4, 7500 ps) = 6.
- R9: WRITE after WRITE, READ after READ and WRITE after READ are bound only by the short and long delays. No turnaround is added to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A column command is presented |
| in_ready | output | 1 | The presented command may be taken on this edge |
| in_is_wr | input | 1 | 1 = WRITE, 0 = READ |
| in_bg | input | BG_W | Target bank group |
| in_bank | input | BANK_W | Target bank within the group |
| in_col | input | COL_W | Column address |
| cmd_o | output | 2 | Bus command: 0 deselect, 1 READ, 2 WRITE |
| cmd_bg_o | output | BG_W | Bank group of the issued command |
| cmd_bank_o | output | BANK_W | Bank of the issued command |
| cmd_col_o | output | COL_W | Column of the issued command |

## Verification
The scoreboard computes the exact issue cycle of every command from its own model of the three limits. A design that issues early breaks a spacing rule. A design that over-counts by one clock, or that waits on a counter that does not apply, issues late and misses the exact cycle.

The directed cases aim at the following confusions:
- A same-group pair sent back to back. A design that swaps the short and long delays issues it at 4 instead of 6 clocks.
- A WRITE followed by a READ in the same group. A design without the turnaround issues at 6 instead of 14 clocks.
- The same WRITE and READ pair in different groups. A design that applies the turnaround across groups wrongly stalls these.
- READ followed by WRITE. A design that applies the turnaround in both directions wrongly stalls these.

A random stream then mixes groups, directions and idle gaps, so counters expire while others are still running.

// File: rtl/col_spacing_pkg.sv
package col_spacing_pkg;

  localparam logic [1:0] BUS_DES = 2'd0;
  localparam logic [1:0] BUS_RD  = 2'd1;
  localparam logic [1:0] BUS_WR  = 2'd2;

  // Picoseconds to clocks, rounded up.
  function automatic int unsigned ps_to_clk(input int unsigned ps, input int unsigned tck_ps);
    return (ps + tck_ps - 1) / tck_ps;
  endfunction

  // Enforced limit: larger of the clock floor and the converted time.
  function automatic int unsigned limit_clk(input int unsigned nck, input int unsigned ps,
                                            input int unsigned tck_ps);
    int unsigned t;
    t = ps_to_clk(ps, tck_ps);
    return (t > nck) ? t : nck;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/spacing_timer.sv
module spacing_timer #(
  parameter int unsigned W    = 4,
  parameter int unsigned LOAD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  output logic         zero,
  output logic [W-1:0] cnt
);
  // The issuing edge counts as the first clock of the gap.
  localparam int unsigned LD = (LOAD > 0) ? LOAD - 1 : 0;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= W'(LD);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(LD));

endmodule

// File: rtl/issue_gate.sv
module issue_gate #(
  parameter int unsigned NUM_BG = 4,
  parameter int unsigned BG_W   = 2
) (
  input  logic              glob_zero,
  input  logic [NUM_BG-1:0] bg_zero,
  input  logic [NUM_BG-1:0] wtr_zero,
  input  logic [BG_W-1:0]   bg,
  input  logic              is_wr,
  output logic              clear
);
  logic own_ok;
  logic turn_ok;

  always_comb begin
    own_ok  = bg_zero[bg];
    turn_ok = is_wr | wtr_zero[bg];   // turnaround guards reads only
    clear   = glob_zero & own_ok & turn_ok;
  end
endmodule

// File: rtl/cmd_out_reg.sv
module cmd_out_reg
  import col_spacing_pkg::*;
#(
  parameter int unsigned BG_W   = 2,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_wr,
  input  logic [BG_W-1:0]   bg,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  output logic [1:0]        cmd_o,
  output logic [BG_W-1:0]   bg_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      cmd_o  <= BUS_DES;
      bg_o   <= '0;
      bank_o <= '0;
      col_o  <= '0;
    end else begin
      cmd_o  <= is_wr ? BUS_WR : BUS_RD;
      bg_o   <= bg;
      bank_o <= bank;
      col_o  <= col;
    end
  end

  assert_des_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == BUS_DES) |-> (bg_o == '0 && bank_o == '0 && col_o == '0));

  assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o != 2'd3);

endmodule

// File: rtl/col_cmd_spacer.sv
module col_cmd_spacer
  import col_spacing_pkg::*;
#(
  parameter int unsigned NUM_BG          = 4,
  parameter int unsigned BANK_W          = 2,
  parameter int unsigned COL_W           = 10,
  parameter int unsigned TCK_PS          = 1250,
  parameter int unsigned CCD_S_NCK       = 4,
  parameter int unsigned CCD_S_PS        = 2500,
  parameter int unsigned CCD_L_NCK       = 5,
  parameter int unsigned CCD_L_PS        = 7500,
  parameter int unsigned WTR_NCK         = 4,
  parameter int unsigned WTR_PS          = 7500,
  parameter int unsigned WR_DATA_END_CLK = 8,
  localparam int unsigned BG_W           = (NUM_BG > 1) ? $clog2(NUM_BG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_wr,
  input  logic [BG_W-1:0]   in_bg,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [COL_W-1:0]  in_col,
  output logic [1:0]        cmd_o,
  output logic [BG_W-1:0]   cmd_bg_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [COL_W-1:0]  cmd_col_o
);
  localparam int unsigned S_CLK   = limit_clk(CCD_S_NCK, CCD_S_PS, TCK_PS);
  localparam int unsigned L_CLK   = limit_clk(CCD_L_NCK, CCD_L_PS, TCK_PS);
  localparam int unsigned WTR_TOT = WR_DATA_END_CLK + limit_clk(WTR_NCK, WTR_PS, TCK_PS);
  localparam int unsigned T_MAX   = max3(S_CLK, L_CLK, WTR_TOT);
  localparam int unsigned TW      = $clog2(T_MAX + 1);
  localparam int unsigned GW      = $clog2(T_MAX + 2);

  // Named internal events.
  logic              fire;
  logic              glob_zero;
  logic [NUM_BG-1:0] bg_zero;
  logic [NUM_BG-1:0] wtr_zero;
  logic [TW-1:0]     glob_cnt;

  assign fire = in_valid & in_ready;

  spacing_timer #(.W(TW), .LOAD(S_CLK)) u_glob (
    .clk(clk), .rst_n(rst_n), .load(fire), .zero(glob_zero), .cnt(glob_cnt));

  for (genvar g = 0; g < NUM_BG; g++) begin : g_bg
    logic          hit;
    logic [TW-1:0] l_cnt;
    logic [TW-1:0] w_cnt;
    assign hit = fire && (in_bg == BG_W'(g));

    spacing_timer #(.W(TW), .LOAD(L_CLK)) u_long (
      .clk(clk), .rst_n(rst_n), .load(hit), .zero(bg_zero[g]), .cnt(l_cnt));

    spacing_timer #(.W(TW), .LOAD(WTR_TOT)) u_turn (
      .clk(clk), .rst_n(rst_n), .load(hit && in_is_wr), .zero(wtr_zero[g]), .cnt(w_cnt));
  end

  issue_gate #(.NUM_BG(NUM_BG), .BG_W(BG_W)) u_gate (
    .glob_zero(glob_zero), .bg_zero(bg_zero), .wtr_zero(wtr_zero),
    .bg(in_bg), .is_wr(in_is_wr), .clear(in_ready));

  cmd_out_reg #(.BG_W(BG_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(fire), .is_wr(in_is_wr), .bg(in_bg),
    .bank(in_bank), .col(in_col), .cmd_o(cmd_o), .bg_o(cmd_bg_o),
    .bank_o(cmd_bank_o), .col_o(cmd_col_o));

  // Gap tracker kept only for the spacing assertions.
  logic [GW-1:0]   since;
  logic [BG_W-1:0] last_bg;
  logic            last_wr;
  logic            have_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since     <= '0;
      last_bg   <= '0;
      last_wr   <= 1'b0;
      have_prev <= 1'b0;
    end else if (fire) begin
      since     <= GW'(1);
      last_bg   <= in_bg;
      last_wr   <= in_is_wr;
      have_prev <= 1'b1;
    end else if (since != GW'(T_MAX + 1)) begin
      since <= since + 1'b1;
    end
  end

  assert_short_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_prev && in_bg != last_bg) |-> (since >= GW'(S_CLK)));

  assert_long_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_prev && in_bg == last_bg) |-> (since >= GW'(L_CLK)));

  assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_prev && last_wr && !in_is_wr && in_bg == last_bg) |-> (since >= GW'(WTR_TOT)));

  assert_one_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cmd_o != BUS_DES && cmd_bg_o == $past(in_bg) && cmd_col_o == $past(in_col)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_bg) && $stable(in_is_wr) && $stable(in_col)));

  assert_first_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !have_prev |-> in_ready);

endmodule

// File: tb/sim_col_cmd_spacer.sv
module sim_col_cmd_spacer;

  localparam int TCK = 1250;
  // Bench restatement of the limits (R8): ceiling by integer division.
  localparam int S_REF   = (4 > (2500 + TCK - 1) / TCK) ? 4 : (2500 + TCK - 1) / TCK;
  localparam int L_REF   = (5 > (7500 + TCK - 1) / TCK) ? 5 : (7500 + TCK - 1) / TCK;
  localparam int TURN    = (4 > (7500 + TCK - 1) / TCK) ? 4 : (7500 + TCK - 1) / TCK;
  localparam int WTR_REF = 8 + TURN;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0;
  logic       in_ready;
  logic       in_is_wr = 0;
  logic [1:0] in_bg = 0;
  logic [1:0] in_bank = 0;
  logic [9:0] in_col = 0;
  logic [1:0] cmd_o;
  logic [1:0] cmd_bg_o;
  logic [1:0] cmd_bank_o;
  logic [9:0] cmd_col_o;

  col_cmd_spacer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_wr(in_is_wr), .in_bg(in_bg), .in_bank(in_bank), .in_col(in_col),
    .cmd_o(cmd_o), .cmd_bg_o(cmd_bg_o), .cmd_bank_o(cmd_bank_o), .cmd_col_o(cmd_col_o));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    bit wr;
    int bg;
    int bank;
    int col;
    int pcyc;
  } item_t;
  item_t q[$];

  int last_any = -100000;
  int last_bg[4];
  int last_wrc[4];
  initial for (int i = 0; i < 4; i++) begin last_bg[i] = -100000; last_wrc[i] = -100000; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: presents one command, pushes the expected item, waits for acceptance.
  task automatic send(input bit wr, input int bg, input int bank, input int col, input int idle);
    item_t it;
    repeat (idle) @(negedge clk);
    @(negedge clk);
    in_valid = 1; in_is_wr = wr; in_bg = 2'(bg); in_bank = 2'(bank); in_col = 10'(col);
    it.wr = wr; it.bg = bg; it.bank = bank; it.col = col; it.pcyc = cyc;
    q.push_back(it);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  // Monitor: pops and compares each issued command against the spacing model.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && cmd_o != 2'd0) begin
        if (q.size() == 0) begin
          check(0, "R1 unexpected issue", int'(cmd_o), 0);
        end else begin
          item_t it;
          int exp_c;
          it = q.pop_front();
          check(cmd_o == (it.wr ? 2'd2 : 2'd1), "R6 command code", int'(cmd_o), it.wr ? 2 : 1);
          check(cmd_bg_o == 2'(it.bg) && cmd_bank_o == 2'(it.bank) && cmd_col_o == 10'(it.col),
                "R1 fields", int'(cmd_col_o), it.col);
          exp_c = it.pcyc + 1;
          if (last_any + S_REF > exp_c) exp_c = last_any + S_REF;           // R2
          if (last_bg[it.bg] + L_REF > exp_c) exp_c = last_bg[it.bg] + L_REF; // R3
          if (!it.wr && last_wrc[it.bg] + WTR_REF > exp_c)
            exp_c = last_wrc[it.bg] + WTR_REF;                               // R4, R9
          check(cyc == exp_c, "R5 issue cycle (R2/R3/R4/R9)", cyc, exp_c);
          last_any = cyc;
          last_bg[it.bg] = cyc;
          if (it.wr) last_wrc[it.bg] = cyc;
        end
      end else if (rst_n) begin
        check(cmd_bg_o == 0 && cmd_bank_o == 0 && cmd_col_o == 0, "R6 deselect fields",
              int'(cmd_col_o), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(cmd_o == 2'd0, "R7 reset deselect", int'(cmd_o), 0);
    check(in_ready == 1'b1, "R7 ready after reset", int'(in_ready), 1);
    // R7: first command immediately; R3: same bank group back to back.
    send(0, 1, 0, 10, 0);
    send(0, 1, 1, 11, 0);
    // R2: different bank group.
    send(0, 2, 0, 12, 0);
    // R4: write then read, same group.
    send(1, 3, 2, 13, 0);
    send(0, 3, 2, 14, 0);
    // R4 does not cross groups: write then read, different groups.
    send(1, 0, 1, 15, 20);
    send(0, 1, 1, 16, 0);
    // R9: read then write, same group; write then write.
    send(0, 2, 3, 17, 20);
    send(1, 2, 3, 18, 0);
    send(1, 2, 0, 19, 0);
    // Mixed random stream.
    for (int i = 0; i < 300; i++)
      send(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 1023), $urandom_range(0, 8));
    repeat (40) @(negedge clk);
    check(q.size() == 0, "R1 all commands issued", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule